// File: doc/BRIEF.md
# Signed Residue Arithmetic Unit

This block adds, subtracts, multiplies and negates signed integers that are held as residues. Each operand arrives as one small residue per odd, pairwise coprime modulus, plus a single bit that is the residue modulo 2. Let M be the product of the odd moduli. A signed value N in [-M, M) is stored as the offset code M + N. Codes below M are negative, and codes from M up to 2M are positive or zero.

Every odd channel works on its own residues. Subtraction adds the channel negation of the second operand. Multiplication reads a per-modulus table indexed by the two operand residues, or uses modular logic, depending on a parameter. The offset correction touches only the modulo-2 bit, because M is zero on every odd channel and one on the modulo-2 channel. After an add or subtract that bit is inverted. After a multiply M is added only when the operand bits differ. Results that leave [-M, M) wrap modulo 2M. The datapath is combinational, and a parameter can place one register stage at the output.

Top module: `rns_signed_alu`

## Requirements
- R1: A value N in [-M, M) is encoded as E = M + N. Odd channel i carries E mod p_i in bits [i*RES_W +: RES_W] of a residue bus, with channel 0 being the first modulus. The separate parity pin carries E mod 2.
- R2: Opcode encoding: 2'b00 add, 2'b01 subtract (a - b), 2'b10 multiply, 2'b11 negate a.
- R3: Add returns the code of a + b, wrapped into [-M, M) modulo 2M.
- R4: Subtract returns the code of a - b, wrapped modulo 2M.
- R5: Multiply returns the code of a * b, wrapped modulo 2M.
- R6: Negate returns the code of -a, wrapped modulo 2M. The parity bit equals that of a, and operand b has no effect on the result.
- R7: When every input residue is below its modulus, every output residue is below its modulus.
- R8: With REG_OUT set, the result appears one clock after the inputs. While reset is low, all output bits are zero.
- R9: Subtracting an operand from itself gives the code of zero: all odd residues 0 and parity 1.
- R10: In a multiply, an odd channel in which either operand residue is zero gives 0 on that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 2 | Operation code |
| a_res | input | NUM_ODD*RES_W | Odd-channel residues of operand a |
| a_par | input | 1 | Modulo-2 residue of operand a |
| b_res | input | NUM_ODD*RES_W | Odd-channel residues of operand b |
| b_par | input | 1 | Modulo-2 residue of operand b |
| y_res | output | NUM_ODD*RES_W | Odd-channel residues of the result |
| y_par | output | 1 | Modulo-2 residue of the result |

## Verification
Every pair of codes in [0, 2M) for the default moduli {3, 7} is applied under all four opcodes, so negative, positive, zero and overflowing results all occur. Mixed-sign pairs separate the two parity corrections of a multiply. Equal pairs in a subtract confirm that self-cancellation lands on the offset code. Sweeping b during negate shows that the second operand is ignored. Operands with a zero residue in a channel exercise the zero rows and columns of the multiply tables.

// File: rtl/rns_pkg.sv
package rns_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'b00,
    OP_SUB = 2'b01,
    OP_MUL = 2'b10,
    OP_NEG = 2'b11
  } rns_op_e;

  // modular sum of two residues already below p
  function automatic int res_add(int x, int y, int p);
    return (x + y) % p;
  endfunction

  // additive inverse inside one channel
  function automatic int res_neg(int x, int p);
    return (p - x) % p;
  endfunction

  // modular product inside one channel
  function automatic int res_mul(int x, int y, int p);
    return (x * y) % p;
  endfunction

  // parity of the offset code after a sum: the raw sum carries 2M, remove one M
  function automatic logic par_after_add(logic pa, logic pb);
    return ~(pa ^ pb);
  endfunction

  // parity after a product: add M only when the operand parities differ
  function automatic logic par_after_mul(logic pa, logic pb);
    return (pa & pb) ^ (pa ^ pb);
  endfunction

endpackage

// File: rtl/rns_chan.sv
module rns_chan
  import rns_pkg::*;
#(
  parameter int P       = 3,
  parameter int RW      = 3,
  parameter bit USE_LUT = 1'b1
) (
  input  rns_op_e         op,
  input  logic [RW-1:0]   a,
  input  logic [RW-1:0]   b,
  output logic [RW-1:0]   y,
  output logic            ok
);

  localparam int ENTRIES = P * P;
  localparam int IW      = $clog2(ENTRIES) + 1;

  logic [RW-1:0] neg_a;
  logic [RW-1:0] neg_b;
  logic [RW-1:0] add_raw;
  logic [RW-1:0] sub_raw;
  logic [RW-1:0] mul_raw;

  assign ok      = (a < RW'(P)) && (b < RW'(P));
  assign neg_a   = RW'(res_neg(int'(a), P));
  assign neg_b   = RW'(res_neg(int'(b), P));
  assign add_raw = RW'(res_add(int'(a), int'(b), P));
  assign sub_raw = RW'(res_add(int'(a), int'(neg_b), P));

  generate
    if (USE_LUT) begin : g_lut
      logic [RW-1:0] lut [ENTRIES];
      logic [IW-1:0] idx;
      for (genvar gi = 0; gi < P; gi++) begin : g_row
        for (genvar gj = 0; gj < P; gj++) begin : g_col
          assign lut[gi*P+gj] = RW'((gi * gj) % P);
        end
      end
      assign idx     = IW'(int'(a) * P + int'(b));
      assign mul_raw = ok ? lut[idx] : '0;
    end else begin : g_arith
      assign mul_raw = RW'(res_mul(int'(a), int'(b), P));
    end
  endgenerate

  always_comb begin
    unique case (op)
      OP_ADD:  y = add_raw;
      OP_SUB:  y = sub_raw;
      OP_MUL:  y = mul_raw;
      default: y = neg_a;
    endcase
  end

endmodule

// File: rtl/rns_par.sv
module rns_par
  import rns_pkg::*;
(
  input  rns_op_e op,
  input  logic    a,
  input  logic    b,
  output logic    y
);

  logic sum_fix;
  logic mul_fix;

  assign sum_fix = par_after_add(a, b);
  assign mul_fix = par_after_mul(a, b);

  always_comb begin
    unique case (op)
      OP_ADD:  y = sum_fix;
      OP_SUB:  y = sum_fix;  // -b keeps parity of b
      OP_MUL:  y = mul_fix;
      default: y = a;        // 2M - E has the parity of E
    endcase
  end

endmodule

// File: rtl/rns_signed_alu.sv
module rns_signed_alu
  import rns_pkg::*;
#(
  parameter int NUM_ODD          = 2,
  parameter int RES_W            = 3,
  parameter int MODULI [NUM_ODD] = '{3, 7},
  parameter bit USE_LUT          = 1'b1,
  parameter bit REG_OUT          = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               op,
  input  logic [NUM_ODD*RES_W-1:0] a_res,
  input  logic                     a_par,
  input  logic [NUM_ODD*RES_W-1:0] b_res,
  input  logic                     b_par,
  output logic [NUM_ODD*RES_W-1:0] y_res,
  output logic                     y_par
);

  localparam int VEC_W = NUM_ODD * RES_W;

  rns_op_e            op_e;
  logic [VEC_W-1:0]   nxt_res;
  logic               nxt_par;
  logic [NUM_ODD-1:0] ch_ok;
  logic               all_ok;

  assign op_e   = rns_op_e'(op);
  assign all_ok = &ch_ok;

  generate
    for (genvar i = 0; i < NUM_ODD; i++) begin : g_ch
      logic [RES_W-1:0] a_ch;
      logic [RES_W-1:0] b_ch;
      logic [RES_W-1:0] y_ch;

      assign a_ch = a_res[i*RES_W +: RES_W];
      assign b_ch = b_res[i*RES_W +: RES_W];
      assign nxt_res[i*RES_W +: RES_W] = y_ch;

      rns_chan #(
        .P       (MODULI[i]),
        .RW      (RES_W),
        .USE_LUT (USE_LUT)
      ) u_chan (
        .op (op_e),
        .a  (a_ch),
        .b  (b_ch),
        .y  (y_ch),
        .ok (ch_ok[i])
      );

      p_res_range_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        ch_ok[i] |-> (y_ch < RES_W'(MODULI[i])));

      p_mul_zero_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_MUL && ch_ok[i] && (a_ch == '0 || b_ch == '0)) |-> (y_ch == '0));
    end
  endgenerate

  rns_par u_par (
    .op (op_e),
    .a  (a_par),
    .b  (b_par),
    .y  (nxt_par)
  );

  p_sub_self_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_SUB && all_ok && a_res == b_res && a_par == b_par)
      |-> (nxt_res == '0 && nxt_par));

  p_neg_par_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    (op_e == OP_NEG) |-> (nxt_par == a_par));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          y_res <= '0;
          y_par <= 1'b0;
        end else begin
          y_res <= nxt_res;
          y_par <= nxt_par;
        end
      end

      p_reset_zero_r8 : assert property (@(posedge clk)
        (!rst_n) |-> (y_res == '0 && !y_par));
    end else begin : g_comb
      assign y_res = nxt_res;
      assign y_par = nxt_par;
    end
  endgenerate

endmodule

// File: tb/rns_signed_alu_test.sv
module rns_signed_alu_test;

  localparam int CLK_PERIOD = 10;
  localparam int P0 = 3;
  localparam int P1 = 7;
  localparam int M  = P0 * P1;
  localparam int M2 = 2 * M;
  localparam int RW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    op = 2'b00;
  logic [2*RW-1:0] a_res = '0;
  logic [2*RW-1:0] b_res = '0;
  logic          a_par = 1'b0;
  logic          b_par = 1'b0;
  logic [2*RW-1:0] y_res;
  logic          y_par;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rns_signed_alu uut (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .a_res (a_res),
    .a_par (a_par),
    .b_res (b_res),
    .b_par (b_par),
    .y_res (y_res),
    .y_par (y_par)
  );

  function automatic int wrap_code(int v);
    int e;
    e = (v + M) % M2;
    if (e < 0) e += M2;
    return e;
  endfunction

  function automatic logic [2*RW-1:0] code_res(int e);
    logic [RW-1:0] r0, r1;
    r0 = RW'(e % P0);
    r1 = RW'(e % P1);
    return {r1, r0};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 200000) begin
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
        finish_run();
      end
    end
  end

  initial begin
    int va, vb, r, e;
    string tag;
    // R8: reset clears the output register
    repeat (3) @(negedge clk);
    a_res = code_res(5); a_par = 1'b1;
    @(negedge clk);
    check(y_res == '0, "R8 reset y_res", int'(y_res), 0);
    check(y_par == 1'b0, "R8 reset y_par", int'(y_par), 0);
    rst_n = 1'b1;

    // R1 R2: codes and opcodes as specified; all pairs of codes
    for (int o = 0; o < 4; o++) begin
      for (int x = 0; x < M2; x++) begin
        for (int y = 0; y < M2; y++) begin
          @(negedge clk);
          op    = 2'(o);
          a_res = code_res(x); a_par = 1'(x % 2);
          b_res = code_res(y); b_par = 1'(y % 2);
          va = x - M;
          vb = y - M;
          case (o)
            0: begin r = va + vb; tag = "R3 add"; end
            1: begin r = va - vb; tag = "R4 sub"; end
            2: begin r = va * vb; tag = "R5 mul"; end
            default: begin r = -va; tag = "R6 neg"; end
          endcase
          e = wrap_code(r);
          @(negedge clk);  // R8: one register stage
          check(y_res == code_res(e), tag, int'(y_res), int'(code_res(e)));
          check(y_par == 1'(e % 2), tag, int'(y_par), e % 2);
          check(int'(y_res[RW-1:0]) < P0 && int'(y_res[2*RW-1:RW]) < P1,
                "R7 range", int'(y_res), int'(code_res(e)));
          if (o == 1 && x == y)
            check(y_res == '0 && y_par == 1'b1, "R9 self sub", int'({y_res, y_par}), 1);
          if (o == 2 && (x % P0 == 0 || y % P0 == 0))
            check(y_res[RW-1:0] == '0, "R10 zero ch0", int'(y_res[RW-1:0]), 0);
          if (o == 2 && (x % P1 == 0 || y % P1 == 0))
            check(y_res[2*RW-1:RW] == '0, "R10 zero ch1", int'(y_res[2*RW-1:RW]), 0);
          if (o == 3)
            check(y_par == a_par, "R6 neg parity", int'(y_par), int'(a_par));
        end
      end
    end
    done = 1'b1;
    finish_run();
  end

endmodule